// File: doc/BRIEF.md
# Lockable GPIO Port Register Block

This block holds the configuration and data registers of one general-purpose I/O port of eight pins. Software reaches it over a simple synchronous bus with a per-bit write mask. From the register contents the block derives, for every pin, the pad output-enable, the driven value, pull-up and pull-down requests and a 1.8 V input-threshold select. The pad levels come back through a two-flop synchroniser and can be read from a read-only data-in register.

Each pin has a lock bit. Once set, it freezes all register bits of that pin: the output value, direction, output type, pull settings and threshold select. The lock bit itself can only be set. It returns to 0 only on reset. Output type selects push-pull or open-drain. In open-drain mode the pad is enabled only to pull low and never drives high.

The bus side is a two-state machine. `ST_IDLE` waits for an access. A read request moves it to `ST_RESP`. That state presents the captured read data with a valid strobe for one cycle. From `ST_RESP`, a further read request stays in `ST_RESP` and any other cycle returns to `ST_IDLE`. A write takes effect at the clock edge where it is requested, in either state.

Top module: `gpio_port_regs`

Register map (3-bit address):

| Address | Register | Meaning |
|---|---|---|
| 0 | data-out | value driven when the pin is an output |
| 1 | direction | 1 = output, 0 = input |
| 2 | output type | 1 = open-drain, 0 = push-pull |
| 3 | pull enable | 1 = pull on |
| 4 | pull select | 1 = pull-down, 0 = pull-up |
| 5 | level select | 1 = 1.8 V threshold, 0 = 3.3 V |
| 6 | lock | write 1 to lock a pin |
| 7 | data-in | read-only, synchronised pad level |

## Requirements
- R1: After reset every register at addresses 0 to 6 reads 0; `pad_oe`, the pull outputs, `pad_lv_sel` and `bus_rvalid` are 0.
- R2: In push-pull mode (output-type bit 0), `pad_oe` equals the direction bit and `pad_out` equals the data-out bit. Direction 1 means output and 0 means input.
- R3: In open-drain mode (output-type bit 1), `pad_oe` is 1 only when the direction bit is 1 and the data-out bit is 0, and `pad_out` is 0.
- R4: `pad_pull_up` is pull-enable AND NOT pull-select, and `pad_pull_dn` is pull-enable AND pull-select. With pull-enable 0 both are 0.
- R5: `pad_lv_sel` follows the level-select register bit for bit.
- R6: A write changes only the bits whose `bus_wmask` bit is 1. Unmasked bits keep their value.
- R7: For a pin whose lock bit is 1, writes to addresses 0 to 5 leave that pin's bit unchanged. Unlocked bits in the same write update normally.
- R8: Writing 0 to a lock bit has no effect, and writing 1 sets it. Only reset clears lock bits.
- R9: Address 7 returns `pad_in` delayed by two clock edges. Writes to address 7 are ignored.
- R10: A read request (`bus_en`=1, `bus_we`=0) at a clock edge gives `bus_rvalid`=1 and the addressed value on `bus_rdata` after that edge, for one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| bus_en | input | 1 | access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | register address |
| bus_wdata | input | 8 | write data |
| bus_wmask | input | 8 | per-bit write enable |
| bus_rdata | output | 8 | read data |
| bus_rvalid | output | 1 | read data valid |
| pad_in | input | 8 | pad input levels |
| pad_oe | output | 8 | pad output enable |
| pad_out | output | 8 | pad output value |
| pad_pull_up | output | 8 | pull-up request |
| pad_pull_dn | output | 8 | pull-down request |
| pad_lv_sel | output | 8 | 1.8 V threshold select |

## Verification
The pad outputs are driven with push-pull and open-drain patterns that mix 0 and 1 bits in both nibbles. This separates the two output-enable rules and would catch a swapped data polarity. The pull patterns set enable and select independently so each of the four combinations appears in one word. The lock scenario writes all-zero and all-one words over a partially locked port. This shows that only the locked bits keep their values, and it tries to clear a lock bit. The data-in scenario reads once in the same cycle as a pad change and once after the synchroniser delay, which fixes the latency at two edges.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int GP_PINS = 8;
    localparam int GP_AW   = 3;

    typedef enum logic [GP_AW-1:0] {
        RG_DOUT  = 3'd0,
        RG_DIR   = 3'd1,
        RG_OTYPE = 3'd2,
        RG_PEN   = 3'd3,
        RG_PSEL  = 3'd4,
        RG_LVL   = 3'd5,
        RG_LOCK  = 3'd6,
        RG_DIN   = 3'd7
    } gp_reg_e;

    localparam int GP_CFG_REGS = 6;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } gp_bus_st_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_sync
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    stage_q[s] <= '0;
                else if (s == 0)
                    stage_q[s] <= d_in;
                else
                    stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
            end
        end
    endgenerate

    assign d_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_pkg::*;
#(
    parameter int PINS = GP_PINS,
    parameter int AW   = GP_AW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [PINS-1:0] wr_data,
    input  logic [PINS-1:0] wr_mask,
    output logic [PINS-1:0] cfg_q [GP_CFG_REGS],
    output logic [PINS-1:0] lock_q
);
    logic [PINS-1:0] upd_mask;
    assign upd_mask = wr_mask & ~lock_q;

    generate
        for (genvar r = 0; r < GP_CFG_REGS; r++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    cfg_q[r] <= '0;
                else if (wr_en && (wr_addr == AW'(r)))
                    cfg_q[r] <= (cfg_q[r] & ~upd_mask) | (wr_data & upd_mask);
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            lock_q <= '0;
        else if (wr_en && (wr_addr == AW'(RG_LOCK)))
            lock_q <= lock_q | (wr_data & wr_mask);
    end

    generate
        for (genvar p = 0; p < PINS; p++) begin : g_chk
            // R7: a locked pin keeps every configuration bit
            a_r7_locked_dout: assert property (@(posedge clk) disable iff (!rst_n)
                lock_q[p] |=> $stable(cfg_q[RG_DOUT][p]));
            a_r7_locked_dir: assert property (@(posedge clk) disable iff (!rst_n)
                lock_q[p] |=> $stable(cfg_q[RG_DIR][p]));
            a_r7_locked_otype: assert property (@(posedge clk) disable iff (!rst_n)
                lock_q[p] |=> $stable(cfg_q[RG_OTYPE][p]));
            // R8: lock bits never fall outside reset
            a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
                lock_q[p] |=> lock_q[p]);
        end
    endgenerate
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] dout,
    input  logic [PINS-1:0] dir,
    input  logic [PINS-1:0] odrain,
    input  logic [PINS-1:0] pull_en,
    input  logic [PINS-1:0] pull_sel,
    input  logic [PINS-1:0] lvl,
    output logic [PINS-1:0] pad_oe,
    output logic [PINS-1:0] pad_out,
    output logic [PINS-1:0] pad_pull_up,
    output logic [PINS-1:0] pad_pull_dn,
    output logic [PINS-1:0] pad_lv_sel
);
    generate
        for (genvar p = 0; p < PINS; p++) begin : g_pin
            always_comb begin
                if (odrain[p]) begin
                    pad_oe[p]  = dir[p] & ~dout[p];
                    pad_out[p] = 1'b0;
                end else begin
                    pad_oe[p]  = dir[p];
                    pad_out[p] = dout[p];
                end
                pad_pull_up[p] = pull_en[p] & ~pull_sel[p];
                pad_pull_dn[p] = pull_en[p] &  pull_sel[p];
                pad_lv_sel[p]  = lvl[p];
            end

            // R3: open-drain pins never drive high
            a_r3_od_no_high: assert property (@(posedge clk) disable iff (!rst_n)
                odrain[p] |-> !(pad_oe[p] && pad_out[p]));
            // R4: never both pulls at once
            a_r4_pull_excl: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0({pad_pull_up[p], pad_pull_dn[p]}));
            // R2: an input pin is never enabled
            a_r2_input_off: assert property (@(posedge clk) disable iff (!rst_n)
                !dir[p] |-> !pad_oe[p]);
        end
    endgenerate
endmodule

// File: rtl/gpio_bus_fsm.sv
module gpio_bus_fsm
    import gpio_pkg::*;
#(
    parameter int PINS = GP_PINS,
    parameter int AW   = GP_AW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_en,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [PINS-1:0] cfg_q [GP_CFG_REGS],
    input  logic [PINS-1:0] lock_q,
    input  logic [PINS-1:0] din_sync,
    output logic            wr_en,
    output logic [PINS-1:0] bus_rdata,
    output logic            bus_rvalid
);
    gp_bus_st_e state_q, state_d;
    logic       rd_req;
    logic [PINS-1:0] rd_mux;

    assign rd_req = bus_en && !bus_we;
    assign wr_en  = bus_en &&  bus_we;

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = rd_req ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = rd_req ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        if (bus_addr == AW'(RG_LOCK))
            rd_mux = lock_q;
        else if (bus_addr == AW'(RG_DIN))
            rd_mux = din_sync;
        else
            rd_mux = cfg_q[bus_addr < AW'(GP_CFG_REGS) ? bus_addr : '0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (rd_req)
            bus_rdata <= rd_mux;
    end

    always_comb bus_rvalid = (state_q == ST_RESP);

    // R10: a read request is answered on the following cycle
    a_r10_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> bus_rvalid);
    a_r10_rvalid_only_read: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !bus_rvalid);
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_pkg::*;
#(
    parameter int PINS        = GP_PINS,
    parameter int AW          = GP_AW,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_en,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [PINS-1:0] bus_wdata,
    input  logic [PINS-1:0] bus_wmask,
    output logic [PINS-1:0] bus_rdata,
    output logic            bus_rvalid,
    input  logic [PINS-1:0] pad_in,
    output logic [PINS-1:0] pad_oe,
    output logic [PINS-1:0] pad_out,
    output logic [PINS-1:0] pad_pull_up,
    output logic [PINS-1:0] pad_pull_dn,
    output logic [PINS-1:0] pad_lv_sel
);
    logic [PINS-1:0] cfg_q [GP_CFG_REGS];
    logic [PINS-1:0] lock_q;
    logic [PINS-1:0] din_sync;
    logic            wr_en;

    gpio_in_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_in   (pad_in),
        .d_sync (din_sync)
    );

    gpio_bus_fsm #(.PINS(PINS), .AW(AW)) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_en     (bus_en),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .cfg_q      (cfg_q),
        .lock_q     (lock_q),
        .din_sync   (din_sync),
        .wr_en      (wr_en),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid)
    );

    gpio_cfg_regs #(.PINS(PINS), .AW(AW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (bus_addr),
        .wr_data (bus_wdata),
        .wr_mask (bus_wmask),
        .cfg_q   (cfg_q),
        .lock_q  (lock_q)
    );

    gpio_pad_drive #(.PINS(PINS)) u_pad (
        .clk         (clk),
        .rst_n       (rst_n),
        .dout        (cfg_q[RG_DOUT]),
        .dir         (cfg_q[RG_DIR]),
        .odrain      (cfg_q[RG_OTYPE]),
        .pull_en     (cfg_q[RG_PEN]),
        .pull_sel    (cfg_q[RG_PSEL]),
        .lvl         (cfg_q[RG_LVL]),
        .pad_oe      (pad_oe),
        .pad_out     (pad_out),
        .pad_pull_up (pad_pull_up),
        .pad_pull_dn (pad_pull_dn),
        .pad_lv_sel  (pad_lv_sel)
    );
endmodule

// File: tb/sim_gpio_port_regs.sv
module sim_gpio_port_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_en = 1'b0;
    logic       bus_we = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_wmask = '0;
    logic [7:0] bus_rdata;
    logic       bus_rvalid;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_oe, pad_out, pad_pull_up, pad_pull_dn, pad_lv_sel;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_port_regs u0 (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wmask(bus_wmask),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pull_up(pad_pull_up),
        .pad_pull_dn(pad_pull_dn), .pad_lv_sel(pad_lv_sel)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d, logic [7:0] m);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_wmask = m;
        @(posedge clk); #1;
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d, output logic v);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(posedge clk); #1;
        d = bus_rdata; v = bus_rvalid;
        bus_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d; logic v;
        chk("R1 pad_oe", pad_oe, 8'h00);
        chk("R1 pull_up", pad_pull_up, 8'h00);
        chk("R1 pull_dn", pad_pull_dn, 8'h00);
        chk("R1 lv_sel", pad_lv_sel, 8'h00);
        chk("R1 rvalid", {7'd0, bus_rvalid}, 8'h00);
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), d, v);
            chk("R1 reg reset", d, 8'h00);
        end
    endtask

    task automatic t_read_timing();
        logic [7:0] d; logic v;
        wr(3'd5, 8'h5A, 8'hFF);
        rd(3'd5, d, v);
        chk("R10 rvalid", {7'd0, v}, 8'h01);
        chk("R10 rdata", d, 8'h5A);
        chk("R5 lv_sel", pad_lv_sel, 8'h5A);
        @(posedge clk); #1;
        chk("R10 rvalid drops", {7'd0, bus_rvalid}, 8'h00);
    endtask

    task automatic t_push_pull();
        wr(3'd1, 8'hFF, 8'hFF);
        wr(3'd0, 8'hA5, 8'hFF);
        chk("R2 pp oe", pad_oe, 8'hFF);
        chk("R2 pp out", pad_out, 8'hA5);
        wr(3'd1, 8'h0F, 8'hFF);
        chk("R2 partial dir oe", pad_oe, 8'h0F);
        wr(3'd1, 8'hFF, 8'hFF);
    endtask

    task automatic t_open_drain();
        wr(3'd2, 8'h0F, 8'hFF);
        chk("R3 od oe", pad_oe, 8'hFA);
        chk("R3 od out", pad_out, 8'hA0);
        wr(3'd2, 8'h00, 8'hFF);
    endtask

    task automatic t_pulls();
        wr(3'd3, 8'h33, 8'hFF);
        wr(3'd4, 8'h0F, 8'hFF);
        chk("R4 pull_up", pad_pull_up, 8'h30);
        chk("R4 pull_dn", pad_pull_dn, 8'h03);
    endtask

    task automatic t_mask();
        logic [7:0] d; logic v;
        wr(3'd0, 8'hFF, 8'h0F);
        rd(3'd0, d, v);
        chk("R6 masked write", d, 8'hAF);
    endtask

    task automatic t_lock();
        logic [7:0] d; logic v;
        wr(3'd6, 8'h81, 8'hFF);
        wr(3'd0, 8'h00, 8'hFF);
        rd(3'd0, d, v);
        chk("R7 dout locked", d, 8'h81);
        wr(3'd1, 8'h00, 8'hFF);
        rd(3'd1, d, v);
        chk("R7 dir locked", d, 8'h81);
        wr(3'd2, 8'hFF, 8'hFF);
        rd(3'd2, d, v);
        chk("R7 otype locked", d, 8'h7E);
        wr(3'd5, 8'h00, 8'hFF);
        chk("R7 lv locked", pad_lv_sel, 8'h00 | (8'h5A & 8'h81));
        wr(3'd6, 8'h00, 8'hFF);
        rd(3'd6, d, v);
        chk("R8 lock not cleared", d, 8'h81);
        wr(3'd6, 8'h02, 8'hFF);
        rd(3'd6, d, v);
        chk("R8 lock set", d, 8'h83);
    endtask

    task automatic t_din();
        logic [7:0] d; logic v;
        @(negedge clk); pad_in = 8'h3C;
        repeat (3) @(posedge clk);
        rd(3'd7, d, v);
        chk("R9 din settled", d, 8'h3C);
        @(negedge clk);
        pad_in = 8'hC3;
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = 3'd7;
        @(posedge clk); #1;
        chk("R9 din not yet", bus_rdata, 8'h3C);
        @(posedge clk); #1;
        chk("R9 din one edge", bus_rdata, 8'h3C);
        @(posedge clk); #1;
        chk("R9 din two edges", bus_rdata, 8'hC3);
        bus_en = 1'b0;
        wr(3'd7, 8'h00, 8'hFF);
        rd(3'd7, d, v);
        chk("R9 din write ignored", d, 8'hC3);
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_read_timing();
        t_push_pull();
        t_open_drain();
        t_pulls();
        t_mask();
        t_lock();
        t_din();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule